// File: doc/BRIEF.md
# Block transfer sequencer between a host handshake port and a memory master

This block moves a fixed number of 32-bit blocks between a host-facing event/acknowledge port and a memory-mapped master port with waitrequest flow control. It has two directions. In load, the host hands one block per event and the block writes it to memory. In unload, the block reads memory and hands each word to the host. Each iteration is lock-step. The host is acknowledged only after the memory side of that iteration has finished, so a host frozen by its own bus stall stays in step with the engine.

A transfer begins with a start pulse. The start pulse carries a direction bit and a 30-bit word base address. In unload, the engine fetches the next word ahead of time. A host read that arrives while that fetch is still in flight is remembered and completed once the data has arrived. Memory latency can be any length: the engine waits on waitrequest and on the read-valid strobe and never counts cycles. After the last iteration it returns to idle and pulses done.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, mem_read_o, mem_write_o, host_ack_o, done_o and busy_o are low, and mem_addr_o, mem_wdata_o, host_rdata_o and iter_o are zero.
- R2: A memory write keeps mem_write_o high, with mem_addr_o and mem_wdata_o unchanged, for every cycle in which mem_waitreq_i is high. The write completes in the first cycle in which mem_write_o is high and mem_waitreq_i is low, and mem_write_o is low in the next cycle.
- R3: A memory read keeps mem_read_o high, with mem_addr_o unchanged, while mem_waitreq_i is high. It drops the read after the first cycle with mem_waitreq_i low. mem_rdata_i is captured in the later cycle in which mem_rvalid_i is high. Read and write are never high together.
- R4: The word address of iteration k (counting from 0) is base + k, modulo 2^30. The base is captured on the accepted start.
- R5: Load (mode_unload_i = 0 at start): a host_evt_i pulse captures host_wdata_i and issues the write one cycle later. host_ack_o pulses for exactly one cycle, in the cycle after the write completes.
- R6: Unload (mode_unload_i = 1 at start): the read for iteration 0 is issued in the cycle after start. The read for iteration k+1 is issued in the same cycle as the acknowledge of iteration k. host_ack_o rises only once the prefetched word has been captured. During the acknowledge cycle, host_rdata_o holds the word at address base + k.
- R7: A transfer runs exactly ITERS iterations. iter_o counts completed iterations and reads ITERS after the transfer ends, until the next accepted start clears it.
- R8: done_o pulses in the same cycle as the final host_ack_o. busy_o is high from the cycle after an accepted start until that cycle, and low afterwards.
- R9: A start pulse while busy_o is high has no effect on the direction, base address, count or memory traffic of the running transfer.
- R10: In unload, a host_evt_i pulse that arrives before the prefetched word has been captured is held. It is acknowledged in the cycle after the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| start_i | input | 1 | Begin a transfer when idle |
| mode_unload_i | input | 1 | Direction at start: 0 load, 1 unload |
| base_addr_i | input | ADDR_W | Word base address captured at start |
| host_evt_i | input | 1 | One-cycle pulse: the host has presented a write (load) or a read (unload) |
| host_wdata_i | input | DATA_W | Host block, valid with host_evt_i in load |
| host_ack_o | output | 1 | One-cycle acknowledge that releases the host |
| host_rdata_o | output | DATA_W | Word for the host, valid while host_ack_o is high in unload |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_read_o | output | 1 | Memory read request |
| mem_write_o | output | 1 | Memory write request |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_waitreq_i | input | 1 | Memory stall for the current request |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_rvalid_i | input | 1 | Memory read data valid |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse with the last acknowledge |
| iter_o | output | CNT_W | Completed iterations of the current or last transfer |

## Verification
The bench drives memory stalls of random length and read latencies of one to three cycles. An engine that dropped a stalled request, or that moved the address or data during a stall, would show up as a missing or wrong word in the bench memory. Unload runs once with host reads issued at once, so that they land during the prefetch, and once with long host gaps. A design that lost an early read would hang, and one that acknowledged before the capture would hand over a stale word. A second start during a load points at an untouched region. Any switch of direction or base would cause reads or writes there. The counter and the done pulse are checked at the boundary of the last iteration.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LD_HOST,
        SQ_LD_MEM,
        SQ_UL_FETCH,
        SQ_UL_READY
    } seq_state_e;

    typedef enum logic [1:0] {
        PT_IDLE,
        PT_WRITE,
        PT_READ,
        PT_RWAIT
    } port_state_e;

endpackage

// File: rtl/xfer_avm_port.sv
module xfer_avm_port
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              issue_wr_i,
    input  logic [ADDR_W-1:0] issue_addr_i,
    input  logic [DATA_W-1:0] issue_data_i,
    output logic              cpl_o,
    output logic [DATA_W-1:0] cpl_rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_read_o,
    output logic              mem_write_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_waitreq_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i
);

    typedef struct packed {
        port_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } port_regs_t;

    port_regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        cpl_o = 1'b0;
        unique case (r_q.st)
            PT_IDLE: begin
                if (issue_i) begin
                    r_d.st   = issue_wr_i ? PT_WRITE : PT_READ;
                    r_d.addr = issue_addr_i;
                    if (issue_wr_i) r_d.data = issue_data_i;
                end
            end
            PT_WRITE: begin
                if (!mem_waitreq_i) begin
                    r_d.st = PT_IDLE;
                    cpl_o  = 1'b1;
                end
            end
            PT_READ: begin
                if (!mem_waitreq_i) r_d.st = PT_RWAIT;
            end
            PT_RWAIT: begin
                if (mem_rvalid_i) begin
                    r_d.st = PT_IDLE;
                    cpl_o  = 1'b1;
                end
            end
            default: r_d.st = PT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= PT_IDLE;
            r_q.addr <= '0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = r_q.data;
    assign mem_write_o = (r_q.st == PT_WRITE);
    assign mem_read_o  = (r_q.st == PT_READ);
    assign cpl_rdata_o = mem_rdata_i;

    assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write_o && mem_waitreq_i) |=>
            (mem_write_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    assert_wr_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write_o && !mem_waitreq_i) |=> !mem_write_o);

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read_o && mem_waitreq_i) |=> (mem_read_o && $stable(mem_addr_o)));

    assert_rd_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read_o && !mem_waitreq_i) |=> !mem_read_o);

    assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read_o && mem_write_o));

endmodule

// File: rtl/xfer_iter_track.sv
module xfer_iter_track #(
    parameter int ITERS  = 260625,
    parameter int ADDR_W = 30,
    parameter int CNT_W  = $clog2(ITERS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              last_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ITERS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ITERS);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  count;
    } trk_regs_t;

    trk_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.base  = base_i;
            t_d.count = '0;
        end else if (step_i) begin
            t_d.count = t_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.base  <= '0;
            t_q.count <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cur_addr_o = t_q.base + ADDR_W'(t_q.count);
    assign count_o    = t_q.count;
    assign last_o     = (t_q.count == LAST_IDX);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.count <= FULL_CNT);

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (t_q.count != '0));

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import xfer_pkg::*;
#(
    parameter int ITERS  = 260625,
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(ITERS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_unload_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic              host_evt_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              host_ack_o,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_read_o,
    output logic              mem_write_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_waitreq_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  iter_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] rdata;
        logic              pend;
        logic              ack;
        logic              done;
    } ctl_regs_t;

    ctl_regs_t c_d, c_q;

    logic              issue, issue_wr;
    logic [ADDR_W-1:0] issue_addr;
    logic              cpl;
    logic [DATA_W-1:0] cpl_rdata;
    logic              trk_load, trk_step, trk_last;
    logic [ADDR_W-1:0] trk_addr;

    xfer_iter_track #(
        .ITERS  (ITERS),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (trk_load),
        .base_i     (base_addr_i),
        .step_i     (trk_step),
        .cur_addr_o (trk_addr),
        .count_o    (iter_o),
        .last_o     (trk_last)
    );

    xfer_avm_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_i       (issue),
        .issue_wr_i    (issue_wr),
        .issue_addr_i  (issue_addr),
        .issue_data_i  (host_wdata_i),
        .cpl_o         (cpl),
        .cpl_rdata_o   (cpl_rdata),
        .mem_addr_o    (mem_addr_o),
        .mem_read_o    (mem_read_o),
        .mem_write_o   (mem_write_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_waitreq_i (mem_waitreq_i),
        .mem_rdata_i   (mem_rdata_i),
        .mem_rvalid_i  (mem_rvalid_i)
    );

    always_comb begin
        c_d        = c_q;
        c_d.ack    = 1'b0;
        c_d.done   = 1'b0;
        issue      = 1'b0;
        issue_wr   = 1'b0;
        issue_addr = trk_addr;
        trk_load   = 1'b0;
        trk_step   = 1'b0;
        unique case (c_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    trk_load = 1'b1;
                    c_d.pend = 1'b0;
                    if (mode_unload_i) begin
                        issue      = 1'b1;
                        issue_addr = base_addr_i;
                        c_d.st     = SQ_UL_FETCH;
                    end else begin
                        c_d.st = SQ_LD_HOST;
                    end
                end
            end
            SQ_LD_HOST: begin
                if (host_evt_i) begin
                    issue    = 1'b1;
                    issue_wr = 1'b1;
                    c_d.st   = SQ_LD_MEM;
                end
            end
            SQ_LD_MEM: begin
                if (cpl) begin
                    c_d.ack  = 1'b1;
                    trk_step = 1'b1;
                    if (trk_last) begin
                        c_d.done = 1'b1;
                        c_d.st   = SQ_IDLE;
                    end else begin
                        c_d.st = SQ_LD_HOST;
                    end
                end
            end
            SQ_UL_FETCH: begin
                if (host_evt_i) c_d.pend = 1'b1;
                if (cpl) begin
                    c_d.rdata = cpl_rdata;
                    c_d.st    = SQ_UL_READY;
                end
            end
            SQ_UL_READY: begin
                if (c_q.pend || host_evt_i) begin
                    c_d.ack  = 1'b1;
                    c_d.pend = 1'b0;
                    trk_step = 1'b1;
                    if (trk_last) begin
                        c_d.done = 1'b1;
                        c_d.st   = SQ_IDLE;
                    end else begin
                        issue      = 1'b1;
                        issue_addr = trk_addr + 1'b1;
                        c_d.st     = SQ_UL_FETCH;
                    end
                end
            end
            default: c_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= SQ_IDLE;
            c_q.rdata <= '0;
            c_q.pend  <= 1'b0;
            c_q.ack   <= 1'b0;
            c_q.done  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign host_ack_o   = c_q.ack;
    assign host_rdata_o = c_q.rdata;
    assign done_o       = c_q.done;
    assign busy_o       = (c_q.st != SQ_IDLE);

    assert_ld_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == SQ_LD_MEM && mem_write_o && !mem_waitreq_i) |=> host_ack_o);

    assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack_o |=> !host_ack_o);

    assert_ul_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == SQ_UL_FETCH && !mem_rvalid_i) |=> !host_ack_o);

    assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (host_ack_o && !busy_o));

    assert_start_ign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == SQ_LD_HOST || c_q.st == SQ_UL_FETCH) && start_i) |=> busy_o);

    assert_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == SQ_UL_READY && c_q.pend) |=> host_ack_o);

endmodule

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;
    localparam int N  = 6;
    localparam int AW = 30;
    localparam int DW = 32;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start_i = 1'b0, mode_i = 1'b0, evt = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [DW-1:0] hwd = '0;
    logic          waitreq = 1'b0, rvalid = 1'b0;
    logic [DW-1:0] rdata = '0;

    logic          host_ack_o, mem_read_o, mem_write_o, busy_o, done_o;
    logic [DW-1:0] host_rdata_o, mem_wdata_o;
    logic [AW-1:0] mem_addr_o;
    logic [CW-1:0] iter_o;

    blk_xfer_seq #(.ITERS(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_unload_i(mode_i),
        .base_addr_i(base_i), .host_evt_i(evt), .host_wdata_i(hwd),
        .host_ack_o(host_ack_o), .host_rdata_o(host_rdata_o),
        .mem_addr_o(mem_addr_o), .mem_read_o(mem_read_o), .mem_write_o(mem_write_o),
        .mem_wdata_o(mem_wdata_o), .mem_waitreq_i(waitreq), .mem_rdata_i(rdata),
        .mem_rvalid_i(rvalid), .busy_o(busy_o), .done_o(done_o), .iter_o(iter_o)
    );

    int n_cmp = 0, n_bad = 0;
    int cycles = 0;
    bit mon_on = 1'b0;
    int knob = 0;
    int rd_seen = 0, done_seen = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    logic [DW-1:0] mem [0:255];

    // behavioural reference state
    int          m_seq = 0, m_port = 0, m_iter = 0;
    bit          m_pend = 0, m_ack = 0, m_done = 0;
    logic [AW-1:0] m_base = '0, m_addr = '0;
    logic [DW-1:0] m_wd = '0, m_rdata = '0;

    // memory responder bookkeeping
    bit            p_rd = 0, p_wr = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_wd = '0;
    int            lat = 0;
    logic [AW-1:0] raddr = '0;

    task automatic chk(input string tag, input string nm,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit cpl, iss, iss_wr;
        logic [AW-1:0] ia;
        cpl = (m_port == 1 && !waitreq) || (m_port == 3 && rvalid);
        iss = 0; iss_wr = 0; ia = '0;
        m_ack = 0; m_done = 0;
        // port transitions first (issue only ever lands on an idle port)
        case (m_port)
            1: if (!waitreq) m_port = 0;
            2: if (!waitreq) m_port = 3;
            3: if (rvalid)   m_port = 0;
            default: ;
        endcase
        case (m_seq)
            0: if (start_i) begin
                m_base = base_i; m_iter = 0; m_pend = 0;
                if (mode_i) begin iss = 1; ia = base_i; m_seq = 3; end
                else m_seq = 1;
            end
            1: if (evt) begin iss = 1; iss_wr = 1; ia = m_base + AW'(m_iter); m_seq = 2; end
            2: if (cpl) begin
                m_ack = 1; m_iter++;
                if (m_iter == N) begin m_done = 1; m_seq = 0; end else m_seq = 1;
            end
            3: begin
                if (evt) m_pend = 1;
                if (cpl) begin m_rdata = rdata; m_seq = 4; end
            end
            4: if (m_pend || evt) begin
                m_ack = 1; m_pend = 0; m_iter++;
                if (m_iter == N) begin m_done = 1; m_seq = 0; end
                else begin iss = 1; ia = m_base + AW'(m_iter); m_seq = 3; end
            end
            default: ;
        endcase
        if (iss) begin
            m_port = iss_wr ? 1 : 2;
            m_addr = ia;
            if (iss_wr) m_wd = hwd;
        end
    endtask

    // per-cycle monitor, reference comparison and memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                bit rd_acc, wr_acc;
                rd_acc = p_rd && !waitreq;
                wr_acc = p_wr && !waitreq;
                model_step();
                chk("R2", "mem_write_o", 64'(mem_write_o), 64'(m_port == 1));
                chk("R3", "mem_read_o",  64'(mem_read_o),  64'(m_port == 2));
                chk("R4", "mem_addr_o",  64'(mem_addr_o),  64'(m_addr));
                chk("R2", "mem_wdata_o", 64'(mem_wdata_o), 64'(m_wd));
                chk((mode_i ? "R6" : "R5"), "host_ack_o", 64'(host_ack_o), 64'(m_ack));
                chk("R6", "host_rdata_o", 64'(host_rdata_o), 64'(m_rdata));
                chk("R8", "busy_o", 64'(busy_o), 64'(m_seq != 0));
                chk("R8", "done_o", 64'(done_o), 64'(m_done));
                chk("R7", "iter_o", 64'(iter_o), 64'(m_iter));
                if (mem_read_o) rd_seen++;
                if (done_o) done_seen++;
                if (wr_acc) mem[p_addr[7:0]] = p_wd;
                if (rd_acc) begin lat = 1 + int'(lfsr[9:8] % 3); raddr = p_addr; end
                if (lat > 0) begin
                    lat--;
                    if (lat == 0) begin rvalid = 1'b1; rdata = mem[raddr[7:0]]; end
                    else rvalid = 1'b0;
                end else begin
                    rvalid = 1'b0;
                    rdata  = lfsr;
                end
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 17);
                lfsr = lfsr ^ (lfsr << 5);
                waitreq = (int'(lfsr[1:0]) < knob);
                p_rd = mem_read_o; p_wr = mem_write_o;
                p_addr = mem_addr_o; p_wd = mem_wdata_o;
            end
        end
    end

    task automatic pulse_start(input bit unl, input logic [AW-1:0] b);
        @(negedge clk); #1;
        start_i = 1'b1; mode_i = unl; base_i = b;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic host_xfer(input int gap, input logic [DW-1:0] d,
                             output logic [DW-1:0] got);
        repeat (gap) @(negedge clk);
        @(negedge clk); #1;
        evt = 1'b1; hwd = d;
        @(negedge clk); #1;
        evt = 1'b0;
        while (!host_ack_o) @(negedge clk);
        got = host_rdata_o;
    endtask

    function automatic logic [DW-1:0] pat(input int b, input int i);
        return 32'hA500_0000 ^ (32'(b) << 8) ^ 32'(i * 32'h0101_0003);
    endfunction

    task automatic run_load(input logic [AW-1:0] b, input int gapmax);
        logic [DW-1:0] g;
        int d0;
        d0 = done_seen;
        pulse_start(1'b0, b);
        for (int i = 0; i < N; i++) host_xfer((gapmax == 0) ? 0 : (i * 7) % gapmax, pat(int'(b), i), g);
        @(negedge clk); #1;
        chk("R8", "busy after load", 64'(busy_o), 64'(0));
        chk("R7", "iter after load", 64'(iter_o), 64'(N));
        chk("R8", "done pulses per load", 64'(done_seen - d0), 64'(1));
        for (int i = 0; i < N; i++)
            chk("R4", "memory word after load", 64'(mem[8'(b) + 8'(i)]), 64'(pat(int'(b), i)));
    endtask

    task automatic run_unload(input logic [AW-1:0] b, input int gap, input string tag);
        logic [DW-1:0] g;
        pulse_start(1'b1, b);
        for (int i = 0; i < N; i++) begin
            host_xfer(gap, 32'h0, g);
            chk(tag, "word handed to host", 64'(g), 64'(pat(int'(b), i)));
        end
        @(negedge clk); #1;
        chk("R8", "busy after unload", 64'(busy_o), 64'(0));
        chk("R7", "iter after unload", 64'(iter_o), 64'(N));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_bad++;
                $display("FAIL watchdog: run did not end, actual=%0d expected<=20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        repeat (3) @(negedge clk);
        chk("R1", "mem_read_o",  64'(mem_read_o), 64'(0));
        chk("R1", "mem_write_o", 64'(mem_write_o), 64'(0));
        chk("R1", "host_ack_o",  64'(host_ack_o), 64'(0));
        chk("R1", "done_o",      64'(done_o), 64'(0));
        chk("R1", "busy_o",      64'(busy_o), 64'(0));
        chk("R1", "mem_addr_o",  64'(mem_addr_o), 64'(0));
        chk("R1", "iter_o",      64'(iter_o), 64'(0));
        #1; rst_n = 1'b1; mon_on = 1'b1;

        knob = 0;
        run_load(30'd16, 0);

        knob = 3;
        rd_seen = 0;
        fork
            run_load(30'd40, 5);
            begin repeat (9) @(negedge clk); pulse_start(1'b1, 30'd100); end
        join
        chk("R9", "reads during load with stray start", 64'(rd_seen), 64'(0));
        for (int i = 0; i < N; i++)
            chk("R9", "region of stray start untouched", 64'(mem[100 + i]), 64'(32'hDEAD_0000 + 32'(100 + i)));

        knob = 2;
        run_unload(30'd16, 0, "R10");
        knob = 3;
        run_unload(30'd40, 8, "R6");
        knob = 1;
        run_unload(30'd16, 1, "R6");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule